// File: doc/BRIEF.md
# Tomasulo Reservation Station Core with Common Data Bus

This block pairs a small pool of reservation stations with a register file that records, for every architectural register, whether its value is present or which station will produce it. An incoming instruction names a destination and two source registers. It is accepted only while a station is free, and it takes the lowest free station, whose index becomes its rename tag. Each source enters the station either as a value or as the tag of its pending producer. The destination register is marked pending on the new tag.

Waiting stations watch a single common data bus. When a broadcast tag matches a pending source, the station latches the value. A station whose two operands both hold values is offered for dispatch to the functional units; the lowest-index ready station goes first. The functional units sit outside the block and report each result against its station. Finished stations queue for the bus. The one that finished first is broadcast first, and one tag goes out per cycle. A broadcast writes a register only when the register's latest-writer tag equals the broadcast tag, so later writers are never overwritten by older results. The broadcasting station is freed in the same edge, because no valid copy of its tag remains once every listener has taken the value.

Top module: `tomasulo_core`

## Requirements
- R1: After reset every station is free (`in_ready` = 1), `disp_valid` and `cdb_valid` are 0, and every register reads valid with a value equal to its own index.
- R2: An instruction is accepted only when `in_valid` and `in_ready` are both high. `in_ready` is 0 while all four stations are busy, and an instruction offered then leaves the register file unchanged.
- R3: An accepted instruction takes the lowest-index free station as its tag. The destination register becomes pending on that tag, and each source is taken as a value when its register is valid and as the register's tag otherwise.
- R4: A waiting station whose pending source tag equals the broadcast tag latches the broadcast value in that edge.
- R5: A source whose producer broadcasts in the same cycle as the allocation is stored directly as the broadcast value.
- R6: `disp_valid` is 1 only when some station waits with both operands valid. The station offered is the lowest-index such station, with its tag and both operand values. It leaves the waiting state in that edge.
- R7: At most one result is broadcast per cycle. Among finished stations, the one that finished earliest is broadcast first, and stations that finish in the same cycle go in order of index. A finished result is broadcast in the cycle after the functional unit reports it at the earliest.
- R8: A broadcast sets a register valid with the broadcast value only when the register is pending on that same tag. A register renamed to a younger tag stays pending.
- R9: The broadcasting station is freed in the broadcast edge, and it can be allocated from the next cycle on.
- R10: When an allocation renames a register in the same cycle as a broadcast that matches that register's old tag, the register ends pending on the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_ready | output | 1 | A station is free and the offer is accepted |
| in_dst | input | 3 | Destination register index |
| in_src_a | input | 3 | First source register index |
| in_src_b | input | 3 | Second source register index |
| disp_valid | output | 1 | A ready station is dispatched this cycle |
| disp_tag | output | 2 | Tag of the dispatched station |
| disp_op_a | output | 16 | First operand value of the dispatched station |
| disp_op_b | output | 16 | Second operand value of the dispatched station |
| done_valid | input | 4 | Per station: its functional unit finishes this cycle |
| done_value | input | 64 | Per station result; station i uses bits [16i+15:16i] |
| cdb_valid | output | 1 | A tagged result is on the bus this cycle |
| cdb_tag | output | 2 | Tag of the broadcast result |
| cdb_value | output | 16 | Value of the broadcast result |
| rd_addr | input | 3 | Register inspected on the read port |
| rd_valid | output | 1 | Inspected register holds its value |
| rd_tag | output | 2 | Latest-writer tag of the inspected register |
| rd_value | output | 16 | Value of the inspected register |

## Verification
The register sweep after reset separates the reset values from any other start state. Sources that are ready at allocation, that wait on a tag, and whose producer broadcasts in the very cycle of allocation each take a different path into the station, and the dispatched operands show which path was taken. Two ready stations at once show the index priority of dispatch. The completion pattern (two stations finishing together, then a lower-index one finishing later) separates oldest-first arbitration from plain index priority. A register written by two instructions shows whether the tag-match rule is kept. A rename made in the same cycle as a matching broadcast shows whether the rename takes priority. A fifth offer to a full pool shows whether the stall is kept.

// File: rtl/rs_pkg.sv
// Package: shared types for the reservation station core.
// Assumes: nothing beyond IEEE 1800-2017.
package rs_pkg;
    // Life cycle of one reservation station.
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } st_e;
endpackage

// File: rtl/tag_regfile.sv
// Module: tag_regfile
// Architectural registers, each with a valid bit and the tag of its
// latest writer. An allocation marks a register pending on a new tag and
// takes priority over a broadcast in the same cycle. A broadcast fills a
// register only when it is pending on exactly that tag.
// Assumes: at most one allocation and one broadcast per cycle.
module tag_regfile #(
    parameter int NREG = 8,
    parameter int NRS  = 4,
    parameter int DW   = 16,
    parameter int NRP  = 3,
    localparam int TW  = $clog2(NRS),
    localparam int RW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [RW-1:0]            wr_reg,
    input  logic [TW-1:0]            wr_tag,
    input  logic                     bc_valid,
    input  logic [TW-1:0]            bc_tag,
    input  logic [DW-1:0]            bc_value,
    input  logic [NRP-1:0][RW-1:0]   rp_addr,
    output logic [NRP-1:0]           rp_valid,
    output logic [NRP-1:0][TW-1:0]   rp_tag,
    output logic [NRP-1:0][DW-1:0]   rp_value,
    output logic [NREG-1:0]          reg_valid_vec,
    output logic [NREG-1:0][TW-1:0]  reg_tag_vec
);
    logic [NREG-1:0]          rv;
    logic [NREG-1:0][TW-1:0]  rt;
    logic [NREG-1:0][DW-1:0]  rd;

    // Register state: reset to value = index, rename on allocation, fill on tag match.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                rv[i] <= 1'b1;
                rt[i] <= '0;
                rd[i] <= DW'(i);
            end else if (wr_en && wr_reg == RW'(i)) begin
                rv[i] <= 1'b0;
                rt[i] <= wr_tag;
            end else if (!rv[i] && bc_valid && rt[i] == bc_tag) begin
                rv[i] <= 1'b1;
                rd[i] <= bc_value;
            end
        end
    end

    // Read ports: plain lookups of the stored state.
    always_comb begin
        for (int p = 0; p < NRP; p++) begin
            rp_valid[p] = rv[rp_addr[p]];
            rp_tag[p]   = rt[rp_addr[p]];
            rp_value[p] = rd[rp_addr[p]];
        end
    end

    assign reg_valid_vec = rv;
    assign reg_tag_vec   = rt;
endmodule

// File: rtl/rs_array.sv
// Module: rs_array
// The reservation stations. Each station waits for two operands, snoops
// the broadcast bus for its pending tags, is dispatched when both operands
// hold values, takes its result from its functional unit and frees itself
// when its own tag is broadcast. Also picks the lowest free station for
// allocation and the lowest ready station for dispatch.
// Assumes: the functional units always accept a dispatch; done_valid is
// only acted on for a station in the executing state.
module rs_array
    import rs_pkg::*;
#(
    parameter int NRS = 4,
    parameter int DW  = 16,
    localparam int TW = $clog2(NRS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic [1:0]               alloc_v,
    input  logic [1:0][TW-1:0]       alloc_t,
    input  logic [1:0][DW-1:0]       alloc_d,
    input  logic                     bc_valid,
    input  logic [TW-1:0]            bc_tag,
    input  logic [DW-1:0]            bc_value,
    input  logic [NRS-1:0]           done_valid,
    input  logic [NRS*DW-1:0]        done_value,
    output logic                     free_any,
    output logic [TW-1:0]            free_idx,
    output logic [NRS-1:0]           free_vec,
    output logic [NRS-1:0]           ready_vec,
    output logic [NRS-1:0]           exec_vec,
    output logic [NRS-1:0]           done_vec,
    output logic                     disp_valid,
    output logic [TW-1:0]            disp_idx,
    output logic [DW-1:0]            disp_op_a,
    output logic [DW-1:0]            disp_op_b,
    output logic [NRS-1:0][DW-1:0]   res_all
);
    logic [NRS-1:0][DW-1:0] opa_all;
    logic [NRS-1:0][DW-1:0] opb_all;

    for (genvar i = 0; i < NRS; i++) begin : g_st
        st_e                  st;
        logic [1:0]           ov;
        logic [1:0][TW-1:0]   ot;
        logic [1:0][DW-1:0]   od;
        logic [DW-1:0]        res;

        // Station life cycle: allocate, snoop, dispatch, complete, free.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st  <= ST_FREE;
                ov  <= '0;
                ot  <= '0;
                od  <= '0;
                res <= '0;
            end else begin
                case (st)
                    ST_FREE: begin
                        if (alloc_en && free_idx == TW'(i)) begin
                            st <= ST_WAIT;
                            ov <= alloc_v;
                            ot <= alloc_t;
                            od <= alloc_d;
                        end
                    end
                    ST_WAIT: begin
                        for (int k = 0; k < 2; k++) begin
                            if (!ov[k] && bc_valid && ot[k] == bc_tag) begin
                                ov[k] <= 1'b1;
                                od[k] <= bc_value;
                            end
                        end
                        if (disp_valid && disp_idx == TW'(i)) begin
                            st <= ST_EXEC;
                        end
                    end
                    ST_EXEC: begin
                        if (done_valid[i]) begin
                            st  <= ST_DONE;
                            res <= done_value[i*DW +: DW];
                        end
                    end
                    default: begin
                        if (bc_valid && bc_tag == TW'(i)) begin
                            st <= ST_FREE;
                        end
                    end
                endcase
            end
        end

        assign free_vec[i]  = (st == ST_FREE);
        assign ready_vec[i] = (st == ST_WAIT) && ov[0] && ov[1];
        assign exec_vec[i]  = (st == ST_EXEC);
        assign done_vec[i]  = (st == ST_DONE);
        assign opa_all[i]   = od[0];
        assign opb_all[i]   = od[1];
        assign res_all[i]   = res;
    end

    // Allocation pick: lowest-index free station.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NRS - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                free_any = 1'b1;
                free_idx = TW'(i);
            end
        end
    end

    // Dispatch pick: lowest-index station with both operands valid.
    always_comb begin
        disp_valid = 1'b0;
        disp_idx   = '0;
        for (int i = NRS - 1; i >= 0; i--) begin
            if (ready_vec[i]) begin
                disp_valid = 1'b1;
                disp_idx   = TW'(i);
            end
        end
    end

    assign disp_op_a = opa_all[disp_idx];
    assign disp_op_b = opb_all[disp_idx];
endmodule

// File: rtl/cdb_arbiter.sv
// Module: cdb_arbiter
// Grants the single broadcast bus to the finished station that has waited
// longest. Every finished station keeps its place in a completion queue;
// the station at place zero wins. Stations finishing in the same cycle
// join the queue in index order behind those already waiting.
// Assumes: a station arrives only from the executing state and leaves
// only by being granted.
module cdb_arbiter #(
    parameter int NRS = 4,
    localparam int TW = $clog2(NRS),
    localparam int PW = (NRS > 1) ? $clog2(NRS) : 1,
    localparam int CW = $clog2(NRS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NRS-1:0]  done_vec,
    input  logic [NRS-1:0]  arrive_vec,
    output logic            grant_valid,
    output logic [TW-1:0]   grant_idx,
    output logic [NRS-1:0]  grant_vec
);
    logic [NRS-1:0][PW-1:0] pos;
    logic [NRS-1:0][CW-1:0] slot;
    logic [CW-1:0]          n_done;
    logic [CW-1:0]          base;
    logic [CW-1:0]          run;

    // Winner: the finished station at the head of the queue.
    always_comb begin
        grant_vec   = '0;
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int i = 0; i < NRS; i++) begin
            if (done_vec[i] && pos[i] == '0) begin
                grant_vec[i] = 1'b1;
                grant_valid  = 1'b1;
                grant_idx    = TW'(i);
            end
        end
    end

    // Queue places for stations arriving this cycle.
    always_comb begin
        n_done = '0;
        for (int i = 0; i < NRS; i++) begin
            n_done = n_done + CW'(done_vec[i]);
        end
        base = n_done - CW'(grant_valid);
        run  = '0;
        for (int i = 0; i < NRS; i++) begin
            slot[i] = base + run;
            run     = run + CW'(arrive_vec[i]);
        end
    end

    // Queue update: new arrivals take their place, waiters move up on a grant.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NRS; i++) begin
            if (!rst_n) begin
                pos[i] <= '0;
            end else if (arrive_vec[i]) begin
                pos[i] <= PW'(slot[i]);
            end else if (done_vec[i] && grant_valid && !grant_vec[i]) begin
                pos[i] <= pos[i] - PW'(1);
            end
        end
    end
endmodule

// File: rtl/tomasulo_core.sv
// Module: tomasulo_core
// Top of the renaming core: stations, tag register file and bus arbiter.
// Renames the two sources of an accepted instruction, bypassing a value
// that is broadcast in the allocation cycle, and drives the bus from the
// granted station's result.
// Assumes: the external functional units accept every dispatch and report
// each result on the done lines of its station.
module tomasulo_core
    import rs_pkg::*;
#(
    parameter int NRS  = 4,
    parameter int NREG = 8,
    parameter int DW   = 16,
    localparam int TW  = $clog2(NRS),
    localparam int RW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [RW-1:0]     in_dst,
    input  logic [RW-1:0]     in_src_a,
    input  logic [RW-1:0]     in_src_b,
    output logic              disp_valid,
    output logic [TW-1:0]     disp_tag,
    output logic [DW-1:0]     disp_op_a,
    output logic [DW-1:0]     disp_op_b,
    input  logic [NRS-1:0]    done_valid,
    input  logic [NRS*DW-1:0] done_value,
    output logic              cdb_valid,
    output logic [TW-1:0]     cdb_tag,
    output logic [DW-1:0]     cdb_value,
    input  logic [RW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [TW-1:0]     rd_tag,
    output logic [DW-1:0]     rd_value
);
    localparam int NRP = 3;

    logic                     alloc_en;
    logic                     free_any;
    logic [TW-1:0]            free_idx;
    logic [NRS-1:0]           free_vec;
    logic [NRS-1:0]           ready_vec;
    logic [NRS-1:0]           exec_vec;
    logic [NRS-1:0]           done_vec;
    logic [NRS-1:0]           grant_vec;
    logic [NRS-1:0][DW-1:0]   res_all;
    logic [NRP-1:0][RW-1:0]   rp_addr;
    logic [NRP-1:0]           rp_valid;
    logic [NRP-1:0][TW-1:0]   rp_tag;
    logic [NRP-1:0][DW-1:0]   rp_value;
    logic [NREG-1:0]          reg_valid_vec;
    logic [NREG-1:0][TW-1:0]  reg_tag_vec;
    logic [1:0]               src_v;
    logic [1:0][TW-1:0]       src_t;
    logic [1:0][DW-1:0]       src_d;

    assign in_ready = free_any;
    assign alloc_en = in_valid && free_any;
    assign rp_addr  = {rd_addr, in_src_b, in_src_a};

    // Source renaming: register value, same-cycle broadcast, or pending tag.
    always_comb begin
        for (int k = 0; k < 2; k++) begin
            src_t[k] = rp_tag[k];
            if (rp_valid[k]) begin
                src_v[k] = 1'b1;
                src_d[k] = rp_value[k];
            end else if (cdb_valid && cdb_tag == rp_tag[k]) begin
                src_v[k] = 1'b1;
                src_d[k] = cdb_value;
            end else begin
                src_v[k] = 1'b0;
                src_d[k] = '0;
            end
        end
    end

    tag_regfile #(
        .NREG (NREG),
        .NRS  (NRS),
        .DW   (DW),
        .NRP  (NRP)
    ) u_rf (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (alloc_en),
        .wr_reg        (in_dst),
        .wr_tag        (free_idx),
        .bc_valid      (cdb_valid),
        .bc_tag        (cdb_tag),
        .bc_value      (cdb_value),
        .rp_addr       (rp_addr),
        .rp_valid      (rp_valid),
        .rp_tag        (rp_tag),
        .rp_value      (rp_value),
        .reg_valid_vec (reg_valid_vec),
        .reg_tag_vec   (reg_tag_vec)
    );

    rs_array #(
        .NRS (NRS),
        .DW  (DW)
    ) u_rs (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_v    (src_v),
        .alloc_t    (src_t),
        .alloc_d    (src_d),
        .bc_valid   (cdb_valid),
        .bc_tag     (cdb_tag),
        .bc_value   (cdb_value),
        .done_valid (done_valid),
        .done_value (done_value),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .free_vec   (free_vec),
        .ready_vec  (ready_vec),
        .exec_vec   (exec_vec),
        .done_vec   (done_vec),
        .disp_valid (disp_valid),
        .disp_idx   (disp_tag),
        .disp_op_a  (disp_op_a),
        .disp_op_b  (disp_op_b),
        .res_all    (res_all)
    );

    cdb_arbiter #(
        .NRS (NRS)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_vec    (done_vec),
        .arrive_vec  (exec_vec & done_valid),
        .grant_valid (cdb_valid),
        .grant_idx   (cdb_tag),
        .grant_vec   (grant_vec)
    );

    assign cdb_value = res_all[cdb_tag];
    assign rd_valid  = rp_valid[2];
    assign rd_tag    = rp_tag[2];
    assign rd_value  = rp_value[2];
endmodule

// File: rtl/tomasulo_core_chk.sv
// Module: tomasulo_core_chk
// Temporal checks on the renaming core, attached to every instance of the
// top through the bind at the end of this file.
// Assumes: synchronous active-low reset on rst_n.
module tomasulo_core_chk #(
    parameter int NRS  = 4,
    parameter int NREG = 8,
    localparam int TW  = $clog2(NRS),
    localparam int RW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_ready,
    input  logic [RW-1:0]           in_dst,
    input  logic [TW-1:0]           free_idx,
    input  logic                    disp_valid,
    input  logic [TW-1:0]           disp_tag,
    input  logic                    cdb_valid,
    input  logic [TW-1:0]           cdb_tag,
    input  logic [NRS-1:0]          ready_vec,
    input  logic [NRS-1:0]          done_vec,
    input  logic [NRS-1:0]          free_vec,
    input  logic [NRS-1:0]          grant_vec,
    input  logic [NREG-1:0]         reg_valid_vec,
    input  logic [NREG-1:0][TW-1:0] reg_tag_vec
);
    logic [NRS-1:0] below_disp;

    // Stations with a lower index than the one being dispatched.
    always_comb below_disp = (NRS'(1) << disp_tag) - NRS'(1);

    // R3: an accepted destination is pending on the tag it was given.
    p_alloc_rename_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !reg_valid_vec[$past(in_dst)]
                                 && reg_tag_vec[$past(in_dst)] == $past(free_idx));

    // R6: the dispatched station is ready.
    p_disp_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ready_vec[disp_tag]);

    // R6: no lower-index station is ready when one is dispatched.
    p_disp_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (ready_vec & below_disp) == '0);

    // R7: the bus carries only a finished station.
    p_bus_from_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> done_vec[cdb_tag]);

    // R7: never more than one grant.
    p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R7: a finished result never waits while the bus is idle.
    p_no_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vec != '0) |-> cdb_valid);

    // R9: a broadcast station is free in the following cycle.
    p_reclaim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |=> free_vec[$past(cdb_tag)]);
endmodule

bind tomasulo_core tomasulo_core_chk #(
    .NRS  (NRS),
    .NREG (NREG)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_dst        (in_dst),
    .free_idx      (free_idx),
    .disp_valid    (disp_valid),
    .disp_tag      (disp_tag),
    .cdb_valid     (cdb_valid),
    .cdb_tag       (cdb_tag),
    .ready_vec     (ready_vec),
    .done_vec      (done_vec),
    .free_vec      (free_vec),
    .grant_vec     (grant_vec),
    .reg_valid_vec (reg_valid_vec),
    .reg_tag_vec   (reg_tag_vec)
);

// File: tb/sim_tomasulo_core.sv
// Bench for tomasulo_core: directed instruction streams with expected
// operands, tags and broadcast order worked out in the bench.
module sim_tomasulo_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_dst, in_src_a, in_src_b;
    logic        disp_valid;
    logic [1:0]  disp_tag;
    logic [15:0] disp_op_a, disp_op_b;
    logic [3:0]  done_valid;
    logic [63:0] done_value;
    logic        cdb_valid;
    logic [1:0]  cdb_tag;
    logic [15:0] cdb_value;
    logic [2:0]  rd_addr;
    logic        rd_valid;
    logic [1:0]  rd_tag;
    logic [15:0] rd_value;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tomasulo_core u0 (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_dst (in_dst), .in_src_a (in_src_a), .in_src_b (in_src_b),
        .disp_valid (disp_valid), .disp_tag (disp_tag),
        .disp_op_a (disp_op_a), .disp_op_b (disp_op_b),
        .done_valid (done_valid), .done_value (done_value),
        .cdb_valid (cdb_valid), .cdb_tag (cdb_tag), .cdb_value (cdb_value),
        .rd_addr (rd_addr), .rd_valid (rd_valid), .rd_tag (rd_tag),
        .rd_value (rd_value)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Next negedge, with inputs returned to idle.
    task automatic step;
        @(negedge clk);
        in_valid   = 1'b0;
        done_valid = '0;
    endtask

    task automatic issue(input int d, input int a, input int b);
        in_valid = 1'b1;
        in_dst   = 3'(d);
        in_src_a = 3'(a);
        in_src_b = 3'(b);
    endtask

    task automatic finish_unit(input int idx, input int val);
        done_valid[idx]          = 1'b1;
        done_value[idx*16 +: 16] = 16'(val);
    endtask

    // Pending register: check valid=0 and tag; valid register: check value.
    task automatic chk_reg(input string req, input int r, input int ev, input int ex);
        rd_addr = 3'(r);
        #1;
        chk(req, int'(rd_valid), ev);
        if (ev != 0) chk(req, int'(rd_value), ex);
        else         chk(req, int'(rd_tag), ex);
    endtask

    task automatic chk_disp(input string req, input int t, input int a, input int b);
        #1;
        chk(req, int'(disp_valid), 1);
        chk(req, int'(disp_tag), t);
        chk(req, int'(disp_op_a), a);
        chk(req, int'(disp_op_b), b);
    endtask

    task automatic chk_bus(input string req, input int t, input int v);
        #1;
        chk(req, int'(cdb_valid), 1);
        chk(req, int'(cdb_tag), t);
        chk(req, int'(cdb_value), v);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_dst = '0; in_src_a = '0; in_src_b = '0;
        done_valid = '0; done_value = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and register sweep.
        #1;
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 disp_valid", int'(disp_valid), 0);
        chk("R1 cdb_valid", int'(cdb_valid), 0);
        for (int r = 0; r < 8; r++) chk_reg("R1 reg", r, 1, r);

        // A: I0 r3 <- r1,r2 into station 0.
        issue(3, 1, 2);
        step;
        // B: I0 dispatches with values; I1 r5 <- r3,r4 waits on tag 0.
        chk_disp("R6 ready src", 0, 1, 2);
        chk_reg("R3 rename", 3, 0, 0);
        issue(5, 3, 4);
        step;
        // C: I1 not ready, nothing dispatched; unit 0 finishes with 3.
        #1;
        chk("R6 not ready", int'(disp_valid), 0);
        finish_unit(0, 3);
        step;
        // D: tag 0 on the bus; I2 r6 <- r3,r0 allocated in the same cycle.
        chk_bus("R7 first broadcast", 0, 3);
        issue(6, 3, 0);
        step;
        // E: I1 captured by snooping, I2 captured at allocation; lower index first.
        chk_disp("R4 snoop capture", 1, 3, 4);
        chk_reg("R8 tag match write", 3, 1, 3);
        chk_reg("R3 rename station2", 6, 0, 2);
        chk("R9 reclaim", int'(in_ready), 1);
        step;
        // F: I2 dispatched with the bypassed value.
        chk_disp("R5 same cycle capture", 2, 3, 0);
        step;
        // N0: I3 r7 <- r1,r1 takes station 0 again.
        issue(7, 1, 1);
        step;
        // N1: I3 dispatches; I4 r5 <- r0,r0 takes station 3.
        chk_disp("R9 reused tag", 0, 1, 1);
        issue(5, 0, 0);
        step;
        // N2: pool full; an offer to r2 must be ignored.
        chk_disp("R6 station3", 3, 0, 0);
        chk("R2 full stall", int'(in_ready), 0);
        chk_reg("R3 younger writer", 5, 0, 3);
        issue(2, 0, 0);
        step;
        // N3: r2 untouched; units 1 and 2 finish together.
        chk_reg("R2 ignored offer", 2, 1, 2);
        finish_unit(1, 7);
        finish_unit(2, 9);
        step;
        // N4: tie goes to lower index; unit 0 finishes later.
        chk_bus("R7 tie by index", 1, 7);
        finish_unit(0, 11);
        step;
        // N5: older station 2 beats later station 0; r5 kept on tag 3.
        chk_bus("R7 oldest first", 2, 9);
        chk_reg("R8 WAW kept", 5, 0, 3);
        #1;
        chk("R9 freed after broadcast", int'(in_ready), 1);
        step;
        // N6: r6 filled; station 0 broadcasts.
        chk_reg("R8 fill r6", 6, 1, 9);
        chk_bus("R7 last queued", 0, 11);
        step;
        // N7: r7 filled, bus idle; unit 3 finishes with 13.
        chk_reg("R8 fill r7", 7, 1, 11);
        #1;
        chk("R7 bus idle", int'(cdb_valid), 0);
        finish_unit(3, 13);
        step;
        // N8: tag 3 broadcasts while I5 r5 <- r5,r5 renames r5 to station 0.
        chk_bus("R7 single result", 3, 13);
        issue(5, 5, 5);
        step;
        // N9: rename wins over the old tag; sources bypassed as 13.
        chk_reg("R10 rename priority", 5, 0, 0);
        chk_disp("R5 bypass both sources", 0, 13, 13);
        step;
        finish_unit(0, 26);
        step;
        chk_bus("R7 final broadcast", 0, 26);
        step;
        chk_reg("R8 final fill", 5, 1, 26);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule